// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block turns 48-bit virtual addresses into 36-bit physical addresses for a core that has two request streams: instruction fetch and load/store. Each stream has its own small first-level buffer. That buffer holds ordinary 4 KB translations and a few large-page (2 MB) translations, and it answers in the cycle of the request. When a first-level buffer misses, the stream looks up one second-level buffer that both streams share. That buffer holds 4 KB translations only. A hit there fills the first-level buffer of the stream that asked, and the stream sees a hit one cycle later.

When the second level also misses, the block raises a walk request carrying the virtual page number. The requesting stream then stalls until an external walker answers on the refill port. A 4 KB answer is written into the shared second level and into the first level of the requester. A large-page answer goes into the first level of the requester only. The flush input invalidates every entry of every buffer in a single cycle. A requester keeps its request and address steady until it sees a hit.

Top module: `xlat_tlb2`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, no buffer holds a valid entry: the next access to any page needs a walk, and neither port reports a hit in the cycle after a flush.
- R2: A first-level hit is reported in the cycle of the request. For a 4 KB entry the physical address is the stored 24-bit frame in bits 35:12 and the virtual bits 11:0 in bits 11:0.
- R3: A first-level miss that hits the second level fills the requester's first level at the next edge. The port shows miss in the request cycle and a hit with the correct address in the next cycle, and no walk is raised.
- R4: When both ports miss the first level in the same cycle and both would hit the second level, the data port is served first: data hits one cycle after the request and instruction hits two cycles after.
- R5: A second-level miss raises `walk_req` one cycle later with `walk_vpn` equal to virtual address bits 47:12. Both stay steady until `walk_fill` is accepted. The port keeps reporting miss, and it hits in the cycle after the fill.
- R6: A 4 KB fill is stored in the second level as well, so the other port later finds that page with a one-cycle miss and no walk.
- R7: A fill with `walk_fill_large` set installs a 2 MB entry into the requester's first level only. Its physical address is `walk_pfn` bits 23:9 in bits 35:21 and the virtual bits 20:0 below them. Any page in the same 2 MB region then hits at once on that port, and the other port still needs a walk for it.
- R8: Each buffer replaces its entries in round-robin order. After 9 new pages have been installed into an 8-entry first level, the first of them has been evicted there but is still held in the second level.
- R9: A port shows neither hit nor miss when it has no request. With a request it shows exactly one of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| if_req | input | 1 | Instruction-side request |
| if_va | input | 48 | Instruction-side virtual address |
| if_hit | output | 1 | Instruction-side translation valid |
| if_pa | output | 36 | Instruction-side physical address |
| if_miss | output | 1 | Instruction-side stall |
| ls_req | input | 1 | Data-side request |
| ls_va | input | 48 | Data-side virtual address |
| ls_hit | output | 1 | Data-side translation valid |
| ls_pa | output | 36 | Data-side physical address |
| ls_miss | output | 1 | Data-side stall |
| walk_req | output | 1 | Page walk wanted |
| walk_vpn | output | 36 | Virtual page number to walk |
| walk_fill | input | 1 | Walker answer valid |
| walk_fill_large | input | 1 | Answer is a 2 MB page |
| walk_pfn | input | 24 | Answered physical frame |

## Verification
Each access is classed by the latency the bench expects: zero cycles for a first-level hit, one cycle for a second-level hit, two cycles for a walk. Comparing that latency with the walks seen separates first-level, second-level and walk paths. Cross-port accesses to pages that one side walked show the difference between a shared second-level entry and a private large entry. An eviction sequence of nine pages confirms the round-robin victim choice. A simultaneous miss on both ports pins down the arbitration order. A seeded random mix of both ports over a page pool larger than the second level, with flushes at random, checks every returned address against a mapping function held in the bench.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic {SIDE_IF = 1'b0, SIDE_LS = 1'b1} xlat_side_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
   parameter int TAG_W   = 36,
   parameter int DATA_W  = 24,
   parameter int ENTRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   generate
      if (ENTRIES < 1) begin : g_bad_depth
         $error("xlat_cam needs at least one entry");
      end
   endgenerate

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];
   logic [IDX_W-1:0]   ptr_q;
   logic [ENTRIES-1:0] match;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         assign match[e] = vld_q[e] && (tag_q[e] == lk_tag);
      end
   endgenerate

   always_comb begin
      lk_data = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match[e]) lk_data = lk_data | data_q[e];
      end
   end
   assign lk_hit = |match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[ptr_q] <= 1'b1;
         ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         tag_q[ptr_q]  <= wr_tag;
         data_q[ptr_q] <= wr_data;
      end
   end

   // a page is only installed after it missed, so no tag is held twice
   assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
endmodule

// File: rtl/xlat_l1.sv
module xlat_l1 #(
   parameter int VPN_W    = 36,
   parameter int PFN_W    = 24,
   parameter int SMALL_N  = 8,
   parameter int LARGE_N  = 2,
   parameter int LG_SHIFT = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   input  logic             sm_wr,
   input  logic [VPN_W-1:0] sm_wr_vpn,
   input  logic [PFN_W-1:0] sm_wr_pfn,
   input  logic             lg_wr,
   input  logic [VPN_W-1:0] lg_wr_vpn,
   input  logic [PFN_W-1:0] lg_wr_pfn
);
   localparam int LG_TAG_W = VPN_W - LG_SHIFT;
   localparam int LG_FRM_W = PFN_W - LG_SHIFT;

   generate
      if (LG_SHIFT < 1 || LG_SHIFT >= PFN_W) begin : g_bad_shift
         $error("xlat_l1 large-page shift out of range");
      end
   endgenerate

   logic             sm_hit;
   logic [PFN_W-1:0] sm_pfn;
   logic             lg_hit;
   logic [LG_FRM_W-1:0] lg_frame;

   xlat_cam #(.TAG_W(VPN_W), .DATA_W(PFN_W), .ENTRIES(SMALL_N)) u_small (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_tag(lk_vpn), .lk_hit(sm_hit), .lk_data(sm_pfn),
      .wr_en(sm_wr), .wr_tag(sm_wr_vpn), .wr_data(sm_wr_pfn));

   generate
      if (LARGE_N > 0) begin : g_large
         xlat_cam #(.TAG_W(LG_TAG_W), .DATA_W(LG_FRM_W), .ENTRIES(LARGE_N)) u_large (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .lk_tag(lk_vpn[VPN_W-1:LG_SHIFT]), .lk_hit(lg_hit), .lk_data(lg_frame),
            .wr_en(lg_wr), .wr_tag(lg_wr_vpn[VPN_W-1:LG_SHIFT]),
            .wr_data(lg_wr_pfn[PFN_W-1:LG_SHIFT]));
      end else begin : g_no_large
         assign lg_hit   = 1'b0;
         assign lg_frame = '0;
      end
   endgenerate

   assign lk_hit = sm_hit | lg_hit;
   assign lk_pfn = sm_hit ? sm_pfn : {lg_frame, lk_vpn[LG_SHIFT-1:0]};
endmodule

// File: rtl/xlat_tlb2.sv
module xlat_tlb2 #(
   parameter int VA_W     = 48,
   parameter int PA_W     = 36,
   parameter int PG_BITS  = 12,
   parameter int LG_BITS  = 21,
   parameter int L1_SMALL = 8,
   parameter int L1_LARGE = 2,
   parameter int L2_N     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                if_req,
   input  logic [VA_W-1:0]     if_va,
   output logic                if_hit,
   output logic [PA_W-1:0]     if_pa,
   output logic                if_miss,
   input  logic                ls_req,
   input  logic [VA_W-1:0]     ls_va,
   output logic                ls_hit,
   output logic [PA_W-1:0]     ls_pa,
   output logic                ls_miss,
   output logic                walk_req,
   output logic [VA_W-PG_BITS-1:0] walk_vpn,
   input  logic                walk_fill,
   input  logic                walk_fill_large,
   input  logic [PA_W-PG_BITS-1:0] walk_pfn
);
   import xlat_pkg::*;

   localparam int VPN_W    = VA_W - PG_BITS;
   localparam int PFN_W    = PA_W - PG_BITS;
   localparam int LG_SHIFT = LG_BITS - PG_BITS;

   generate
      if (LG_BITS <= PG_BITS || LG_BITS >= PA_W) begin : g_bad_large
         $error("xlat_tlb2 large-page size must exceed the base page");
      end
      if (PA_W > VA_W) begin : g_bad_width
         $error("xlat_tlb2 physical width exceeds virtual width");
      end
   endgenerate

   logic [VPN_W-1:0] if_vpn, ls_vpn;
   logic             if_l1_hit, ls_l1_hit;
   logic [PFN_W-1:0] if_l1_pfn, ls_l1_pfn;

   assign if_vpn = if_va[VA_W-1:PG_BITS];
   assign ls_vpn = ls_va[VA_W-1:PG_BITS];

   // walker state
   logic             busy_q;
   xlat_side_e       owner_q;
   logic [VPN_W-1:0] wvpn_q;

   logic if_blocked, ls_blocked, gnt_if, gnt_ls, any_gnt;
   logic [VPN_W-1:0] l2_tag;
   logic             l2_hit;
   logic [PFN_W-1:0] l2_pfn;
   logic             take_fill, start_walk;

   assign if_hit  = if_req &  if_l1_hit;
   assign if_miss = if_req & ~if_l1_hit;
   assign ls_hit  = ls_req &  ls_l1_hit;
   assign ls_miss = ls_req & ~ls_l1_hit;
   assign if_pa   = {if_l1_pfn, if_va[PG_BITS-1:0]};
   assign ls_pa   = {ls_l1_pfn, ls_va[PG_BITS-1:0]};

   assign if_blocked = busy_q && (owner_q == SIDE_IF);
   assign ls_blocked = busy_q && (owner_q == SIDE_LS);
   assign gnt_ls  = ls_miss & ~ls_blocked;
   assign gnt_if  = if_miss & ~if_blocked & ~gnt_ls;
   assign any_gnt = gnt_ls | gnt_if;
   assign l2_tag  = gnt_ls ? ls_vpn : if_vpn;

   assign take_fill  = busy_q & walk_fill;
   assign start_walk = any_gnt & ~l2_hit & ~busy_q;

   logic fill_if, fill_ls;
   assign fill_if = take_fill && (owner_q == SIDE_IF);
   assign fill_ls = take_fill && (owner_q == SIDE_LS);

   xlat_l1 #(.VPN_W(VPN_W), .PFN_W(PFN_W), .SMALL_N(L1_SMALL),
             .LARGE_N(L1_LARGE), .LG_SHIFT(LG_SHIFT)) u_l1_if (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_vpn(if_vpn), .lk_hit(if_l1_hit), .lk_pfn(if_l1_pfn),
      .sm_wr((gnt_if & l2_hit) | (fill_if & ~walk_fill_large)),
      .sm_wr_vpn(fill_if ? wvpn_q : if_vpn),
      .sm_wr_pfn(fill_if ? walk_pfn : l2_pfn),
      .lg_wr(fill_if & walk_fill_large), .lg_wr_vpn(wvpn_q), .lg_wr_pfn(walk_pfn));

   xlat_l1 #(.VPN_W(VPN_W), .PFN_W(PFN_W), .SMALL_N(L1_SMALL),
             .LARGE_N(L1_LARGE), .LG_SHIFT(LG_SHIFT)) u_l1_ls (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_vpn(ls_vpn), .lk_hit(ls_l1_hit), .lk_pfn(ls_l1_pfn),
      .sm_wr((gnt_ls & l2_hit) | (fill_ls & ~walk_fill_large)),
      .sm_wr_vpn(fill_ls ? wvpn_q : ls_vpn),
      .sm_wr_pfn(fill_ls ? walk_pfn : l2_pfn),
      .lg_wr(fill_ls & walk_fill_large), .lg_wr_vpn(wvpn_q), .lg_wr_pfn(walk_pfn));

   xlat_cam #(.TAG_W(VPN_W), .DATA_W(PFN_W), .ENTRIES(L2_N)) u_l2 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_tag(l2_tag), .lk_hit(l2_hit), .lk_data(l2_pfn),
      .wr_en(take_fill & ~walk_fill_large), .wr_tag(wvpn_q), .wr_data(walk_pfn));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         owner_q <= SIDE_IF;
         wvpn_q  <= '0;
      end else if (start_walk) begin
         busy_q  <= 1'b1;
         owner_q <= gnt_ls ? SIDE_LS : SIDE_IF;
         wvpn_q  <= l2_tag;
      end else if (take_fill) begin
         busy_q  <= 1'b0;
      end
   end

   assign walk_req = busy_q;
   assign walk_vpn = wvpn_q;

   assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !if_hit && !ls_hit);
   assert_walk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_fill) |=> walk_req && $stable(walk_vpn));
   assert_walk_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(walk_req) |-> $past(if_miss || ls_miss));
   assert_excl_if_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(if_hit && if_miss) && !(ls_hit && ls_miss));
endmodule

// File: tb/tb_xlat_tlb2.sv
module tb_xlat_tlb2;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        if_req = 1'b0, ls_req = 1'b0;
   logic [47:0] if_va = '0, ls_va = '0;
   logic        if_hit, if_miss, ls_hit, ls_miss;
   logic [35:0] if_pa, ls_pa;
   logic        walk_req;
   logic [35:0] walk_vpn;
   logic        walk_fill = 1'b0, walk_fill_large = 1'b0;
   logic [23:0] walk_pfn = '0;

   int checks = 0;
   int errors = 0;
   bit big_mode = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlat_tlb2 dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .if_req(if_req), .if_va(if_va), .if_hit(if_hit), .if_pa(if_pa), .if_miss(if_miss),
      .ls_req(ls_req), .ls_va(ls_va), .ls_hit(ls_hit), .ls_pa(ls_pa), .ls_miss(ls_miss),
      .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_fill(walk_fill),
      .walk_fill_large(walk_fill_large), .walk_pfn(walk_pfn));

   function automatic logic [23:0] map_pfn(input logic [35:0] vpn);
      return vpn[23:0] ^ {vpn[35:24], 12'hA5C};
   endfunction

   function automatic logic [35:0] small_pa(input logic [47:0] va);
      return {map_pfn(va[47:12]), va[11:0]};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   // side 1 = load/store, 0 = fetch; exp_lat < 0 accepts any latency up to 2
   task automatic access(input bit side, input logic [47:0] va, input logic [35:0] exp_pa,
                         input int exp_lat, input int exp_walks, input string rq);
      int lat = 0;
      int walks = 0;
      bit done = 1'b0;
      bit first_miss;
      logic [35:0] got;
      @(negedge clk);
      if (side) begin ls_req = 1'b1; ls_va = va; end
      else      begin if_req = 1'b1; if_va = va; end
      #1;
      first_miss = side ? ls_miss : if_miss;
      while (!done) begin
         if (side ? ls_hit : if_hit) begin
            done = 1'b1;
            got = side ? ls_pa : if_pa;
            chk(got == exp_pa, rq, "pa", 64'(got), 64'(exp_pa));
         end else begin
            if (walk_req && !walk_fill) begin
               walks++;
               chk(walk_vpn == va[47:12], "R5", "walk_vpn", 64'(walk_vpn), 64'(va[47:12]));
               walk_fill = 1'b1;
               walk_fill_large = big_mode;
               walk_pfn = map_pfn(walk_vpn);
            end
            @(negedge clk);
            walk_fill = 1'b0;
            lat++;
            #1;
            if (lat > 20) begin
               chk(1'b0, rq, "no hit", 64'(lat), 64'(exp_lat));
               done = 1'b1;
            end
         end
      end
      if_req = 1'b0;
      ls_req = 1'b0;
      if (exp_lat >= 0) begin
         chk(lat == exp_lat, rq, "latency", 64'(lat), 64'(exp_lat));
         chk(walks == exp_walks, rq, "walks", 64'(walks), 64'(exp_walks));
         if (exp_lat > 0) chk(first_miss, rq, "miss flag", 64'(first_miss), 64'd1);
      end else begin
         chk(lat <= 2 && walks <= 1, rq, "random latency", 64'(lat), 64'd2);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R5", "watchdog", 64'd0, 64'd1);
      summary();
   end

   initial begin
      logic [47:0] va_a, va_c, lg1, lg2;
      logic [35:0] lg_exp;
      logic [23:0] m1;
      int seed;
      seed = $urandom(32'd1357);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R9 idle outputs, R1 nothing valid
      chk(!if_hit && !if_miss && !ls_hit && !ls_miss, "R9", "idle", 64'({if_hit, if_miss, ls_hit, ls_miss}), 64'd0);
      chk(!walk_req, "R1", "walk idle", 64'(walk_req), 64'd0);

      // R1 / R5 first access walks, R2 repeat hits at once
      va_a = 48'h0123_4567_8ABC;
      access(1'b1, va_a, small_pa(va_a), 2, 1, "R5");
      access(1'b1, va_a, small_pa(va_a), 0, 0, "R2");
      access(1'b1, va_a ^ 48'h0000_0000_0FFF, small_pa(va_a ^ 48'h0FFF), 0, 0, "R2");
      // R6: other port finds page in shared level, R3 one-cycle latency
      access(1'b0, va_a, small_pa(va_a), 1, 0, "R6");
      access(1'b0, va_a, small_pa(va_a), 0, 0, "R3");
      // R1 flush
      do_flush();
      access(1'b1, va_a, small_pa(va_a), 2, 1, "R1");

      // R4 arbitration
      do_flush();
      va_c = 48'h0BEE_F00D_1234;
      access(1'b0, va_c, small_pa(va_c), 2, 1, "R4");
      access(1'b1, va_a, small_pa(va_a), 2, 1, "R4");
      @(negedge clk);
      if_req = 1'b1; if_va = va_a; ls_req = 1'b1; ls_va = va_c;
      #1;
      chk(if_miss && ls_miss, "R4", "both miss", 64'({if_miss, ls_miss}), 64'd3);
      @(negedge clk); #1;
      chk(ls_hit && ls_pa == small_pa(va_c), "R4", "data first", 64'(ls_pa), 64'(small_pa(va_c)));
      chk(if_miss, "R4", "fetch waits", 64'(if_miss), 64'd1);
      @(negedge clk); #1;
      chk(if_hit && if_pa == small_pa(va_a), "R4", "fetch second", 64'(if_pa), 64'(small_pa(va_a)));
      if_req = 1'b0; ls_req = 1'b0;

      // R7 large page
      do_flush();
      lg1 = 48'h0000_4020_1ABC;
      lg2 = lg1 + 48'h0000_0003_5000;
      m1 = map_pfn(lg1[47:12]);
      big_mode = 1'b1;
      access(1'b1, lg1, {m1[23:9], lg1[20:0]}, 2, 1, "R7");
      lg_exp = {m1[23:9], lg2[20:0]};
      access(1'b1, lg2, lg_exp, 0, 0, "R7");
      big_mode = 1'b0;
      access(1'b0, lg2, small_pa(lg2), 2, 1, "R7");

      // R8 round-robin eviction
      do_flush();
      for (int p = 0; p < 9; p++)
         access(1'b1, {12'h7A0, 24'(p * 4099 + 17), 12'h040}, small_pa({12'h7A0, 24'(p * 4099 + 17), 12'h040}), 2, 1, "R8");
      access(1'b1, {12'h7A0, 24'(17), 12'h040}, small_pa({12'h7A0, 24'(17), 12'h040}), 1, 0, "R8");
      access(1'b1, {12'h7A0, 24'(8 * 4099 + 17), 12'h040}, small_pa({12'h7A0, 24'(8 * 4099 + 17), 12'h040}), 0, 0, "R8");

      // random mix, R2 R3 R5 R6
      for (int n = 0; n < 400; n++) begin
         logic [47:0] rva;
         int pg;
         pg = int'($urandom % 24);
         rva = {12'h3C0 + 12'(pg), 24'(pg * 37 + 5), 12'($urandom)};
         if (($urandom % 40) == 0) do_flush();
         access(1'($urandom), rva, small_pa(rva), -1, 0, "R3");
      end
      summary();
   end
endmodule